// File: doc/BRIEF.md
# Interrupt Message Dispatcher with Destination Fan-out

This block turns one interrupt line request into zero or more outgoing interrupt messages. A request arrives on a valid/ready handshake. It carries the line number together with the routing entry configured for that line: vector, delivery mode, a physical/logical destination flag, a mask bit and an 8-bit destination.

The block screens the request in a fixed order:

1. A line number outside the table raises a one-cycle range error.
2. A masked entry is consumed silently.
3. A reserved delivery mode raises a one-cycle fatal-mode error.

A request that passes these checks becomes messages on a valid/ready output.

- **Physical destination:** one message is sent, addressed to the whole destination value.
- **Logical destination:** the destination is a bitmask. One message goes to target ID k for every set bit k, lowest bit first.

While a fan-out is in progress, no new request is taken.

Top module: `int_dispatch`

## Requirements
- R1: After reset, reqReady is 1, while msgValid, errRange and errReserved are 0.
- R2: An accepted request whose line number is NUM_LINES or above drives errRange high for exactly the cycle after acceptance and produces no message. This check takes precedence over every other check.
- R3: An accepted in-range request with the mask bit set produces no message and no error flag.
- R4: An accepted, in-range, unmasked request with delivery mode code 3 or 6 drives errReserved high for the cycle after acceptance and produces no message. Codes 0, 1, 2, 4, 5 and 7 are legal. A set mask bit takes precedence over a reserved code.
- R5: Every message carries the vector, the 3-bit delivery mode and the destination-mode flag of the request that caused it.
- R6: With the destination-mode flag at 0 (physical), exactly one message is sent, and its msgTarget equals the full 8-bit destination.
- R7: With the flag at 1 (logical), one message is sent per set destination bit k, with msgTarget = k. The messages go out in ascending k.
- R8: A logical request with destination 0 produces no message and no error, and reqReady stays 1.
- R9: reqReady is 0 from the cycle after a message-producing request is accepted until the cycle after the last message is taken (msgValid and msgReady both high).
- R10: While msgValid is high and msgReady is low, msgValid and all message fields hold their values into the next cycle.
- R11: The first message of a request appears with msgValid high in the cycle after acceptance. Each following message of a fan-out appears in the cycle after the previous one is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Dispatcher idle, request accepted this cycle if valid |
| reqLine | input | LINE_W | Interrupt line number |
| reqVector | input | VEC_W | Vector from the line's entry |
| reqMode | input | 3 | Delivery mode code |
| reqLogical | input | 1 | 0 physical, 1 logical destination |
| reqMask | input | 1 | Entry masked |
| reqDest | input | DEST_W | Destination ID or bitmask |
| msgValid | output | 1 | Message present |
| msgReady | input | 1 | Downstream takes the message |
| msgTarget | output | DEST_W | Target ID of this message |
| msgVector | output | VEC_W | Vector |
| msgMode | output | 3 | Delivery mode |
| msgLogical | output | 1 | Destination-mode flag |
| errRange | output | 1 | One-cycle pulse: line out of range |
| errReserved | output | 1 | One-cycle pulse: reserved delivery mode |

## Verification
All outputs come from registers, so the response to a request accepted at one clock edge is due in the cycle after that edge:

- an error pulse, or
- the first message, or
- reqReady remaining high.

Each following fan-out message is due one cycle after the previous one is taken. The bench drives inputs on the falling edge and steps a behavioural queue model on the rising edge. It then compares every output against that model on the next falling edge, so every result is checked in exactly the cycle it is due. Downstream ready is toggled at random to exercise hold and back-pressure.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef enum logic {ST_IDLE, ST_SEND} dispState_t;

  typedef struct packed {
    logic load;     // capture request fields into the datapath
    logic advance;  // current message taken, drop its pending bit
  } ctrlStrobes_t;

  localparam logic [2:0] MODE_RSV_LO = 3'd3;
  localparam logic [2:0] MODE_RSV_HI = 3'd6;
endpackage

// File: rtl/dispatch_datapath.sv
module dispatch_datapath #(
  parameter int DEST_W = 8,
  parameter int VEC_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dispatch_pkg::ctrlStrobes_t strobes,
  input  logic [VEC_W-1:0]          reqVector,
  input  logic [2:0]                reqMode,
  input  logic                      reqLogical,
  input  logic [DEST_W-1:0]         reqDest,
  output logic                      lastOne,
  output logic [DEST_W-1:0]         msgTarget,
  output logic [VEC_W-1:0]          msgVector,
  output logic [2:0]                msgMode,
  output logic                      msgLogical
);
  localparam int IDX_W = $clog2(DEST_W);

  logic [DEST_W-1:0] destQ;
  logic [DEST_W-1:0] pendQ;
  logic [IDX_W-1:0]  lowIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destQ      <= '0;
      pendQ      <= '0;
      msgVector  <= '0;
      msgMode    <= '0;
      msgLogical <= 1'b0;
    end else if (strobes.load) begin
      destQ      <= reqDest;
      pendQ      <= reqLogical ? reqDest : DEST_W'(1);
      msgVector  <= reqVector;
      msgMode    <= reqMode;
      msgLogical <= reqLogical;
    end else if (strobes.advance) begin
      pendQ <= pendQ & (pendQ - DEST_W'(1));
    end
  end

  // lowest pending bit wins
  always_comb begin
    lowIdx = '0;
    for (int i = DEST_W - 1; i >= 0; i--) begin
      if (pendQ[i]) lowIdx = IDX_W'(i);
    end
  end

  assign lastOne   = ((pendQ & (pendQ - DEST_W'(1))) == '0);
  assign msgTarget = msgLogical ? {{(DEST_W-IDX_W){1'b0}}, lowIdx} : destQ;
endmodule

// File: rtl/dispatch_control.sv
module dispatch_control #(
  parameter int NUM_LINES = 24,
  parameter int LINE_W    = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [LINE_W-1:0]          reqLine,
  input  logic [2:0]                 reqMode,
  input  logic                       reqLogical,
  input  logic                       reqMask,
  input  logic                       destZero,
  input  logic                       lastOne,
  input  logic                       msgReady,
  output logic                       reqReady,
  output logic                       msgValid,
  output logic                       errRange,
  output logic                       errReserved,
  output dispatch_pkg::ctrlStrobes_t strobes
);
  import dispatch_pkg::*;

  localparam logic [LINE_W:0] LINE_LIMIT = (LINE_W+1)'(NUM_LINES);

  dispState_t stateQ, stateD;
  logic accept, badLine, rsvMode, fire, taken;

  assign reqReady = (stateQ == ST_IDLE);
  assign msgValid = (stateQ == ST_SEND);
  assign accept   = reqValid && reqReady;
  assign badLine  = ({1'b0, reqLine} >= LINE_LIMIT);
  assign rsvMode  = (reqMode == MODE_RSV_LO) || (reqMode == MODE_RSV_HI);
  assign fire     = accept && !badLine && !reqMask && !rsvMode && !(reqLogical && destZero);
  assign taken    = msgValid && msgReady;

  assign strobes.load    = fire;
  assign strobes.advance = taken;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (fire) stateD = ST_SEND;
      ST_SEND: if (taken && lastOne) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      errRange    <= 1'b0;
      errReserved <= 1'b0;
    end else begin
      stateQ      <= stateD;
      errRange    <= accept && badLine;
      errReserved <= accept && !badLine && !reqMask && rsvMode;
    end
  end
endmodule

// File: rtl/int_dispatch.sv
module int_dispatch #(
  parameter int NUM_LINES = 24,
  parameter int LINE_W    = 5,
  parameter int DEST_W    = 8,
  parameter int VEC_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [VEC_W-1:0]  reqVector,
  input  logic [2:0]        reqMode,
  input  logic              reqLogical,
  input  logic              reqMask,
  input  logic [DEST_W-1:0] reqDest,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [DEST_W-1:0] msgTarget,
  output logic [VEC_W-1:0]  msgVector,
  output logic [2:0]        msgMode,
  output logic              msgLogical,
  output logic              errRange,
  output logic              errReserved
);
  dispatch_pkg::ctrlStrobes_t strobes;
  logic lastOne;

  dispatch_control #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLine(reqLine),
    .reqMode(reqMode), .reqLogical(reqLogical), .reqMask(reqMask),
    .destZero(reqDest == '0), .lastOne(lastOne), .msgReady(msgReady),
    .reqReady(reqReady), .msgValid(msgValid), .errRange(errRange),
    .errReserved(errReserved), .strobes(strobes)
  );

  dispatch_datapath #(.DEST_W(DEST_W), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqVector(reqVector),
    .reqMode(reqMode), .reqLogical(reqLogical), .reqDest(reqDest),
    .lastOne(lastOne), .msgTarget(msgTarget), .msgVector(msgVector),
    .msgMode(msgMode), .msgLogical(msgLogical)
  );
endmodule

// File: rtl/dispatch_checker.sv
module dispatch_checker #(
  parameter int LINE_W = 5,
  parameter int DEST_W = 8,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [LINE_W-1:0] reqLine,
  input logic [VEC_W-1:0]  reqVector,
  input logic [2:0]        reqMode,
  input logic              reqLogical,
  input logic              reqMask,
  input logic [DEST_W-1:0] reqDest,
  input logic              msgValid,
  input logic              msgReady,
  input logic [DEST_W-1:0] msgTarget,
  input logic [VEC_W-1:0]  msgVector,
  input logic [2:0]        msgMode,
  input logic              msgLogical,
  input logic              errRange,
  input logic              errReserved
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgTarget) && $stable(msgVector)
                              && $stable(msgMode) && $stable(msgLogical));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> !reqReady);

  assert_range_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    errRange |-> $past(reqValid && reqReady) && !msgValid && !errReserved);

  assert_reserved_R4: assert property (@(posedge clk) disable iff (!rstN)
    errReserved |-> !msgValid && $past(reqValid && reqReady && !reqMask
                                       && (reqMode == 3'd3 || reqMode == 3'd6)));

  assert_ascending_R7: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgLogical && $past(msgValid && msgReady) |-> msgTarget > $past(msgTarget));

  assert_target_span_R7: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgLogical |-> msgTarget < DEST_W);

  assert_no_legal_fault_R4: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> msgMode != 3'd3 && msgMode != 3'd6);
endmodule

bind int_dispatch dispatch_checker #(.LINE_W(LINE_W), .DEST_W(DEST_W), .VEC_W(VEC_W)) chk (.*);

// File: tb/tb_int_dispatch.sv
`timescale 1ns/1ps
module tb_int_dispatch;
  localparam int NUM_LINES = 24;

  logic       clk = 0, rstN = 0;
  logic       reqValid = 0, reqLogical = 0, reqMask = 0, msgReady = 1;
  logic [4:0] reqLine = 0;
  logic [7:0] reqVector = 0, reqDest = 0;
  logic [2:0] reqMode = 0;
  logic       reqReady, msgValid, msgLogical, errRange, errReserved;
  logic [7:0] msgTarget, msgVector;
  logic [2:0] msgMode;

  int errors = 0, checks = 0, cycles = 0;
  int readyRandom = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  int_dispatch dut (.*);

  // behavioural model
  int       q[$];
  logic [7:0] mVec; logic [2:0] mMode; logic mLog;
  logic     mErrR = 0, mErrS = 0;

  always @(posedge clk) begin
    mErrR = 0; mErrS = 0;
    if (!rstN) q.delete();
    else if (q.size() > 0) begin
      if (msgReady) void'(q.pop_front());
    end else if (reqValid) begin
      if (reqLine >= NUM_LINES) mErrR = 1;
      else if (reqMask) ;
      else if (reqMode == 3 || reqMode == 6) mErrS = 1;
      else begin
        mVec = reqVector; mMode = reqMode; mLog = reqLogical;
        if (!reqLogical) q.push_back(int'(reqDest));
        else for (int k = 0; k < 8; k++) if (reqDest[k]) q.push_back(k);
      end
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", curReq, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check("reqReady", reqReady, q.size() == 0);
      check("msgValid", msgValid, q.size() > 0);
      check("errRange", errRange, mErrR);
      check("errReserved", errReserved, mErrS);
      if (q.size() > 0 && msgValid) begin
        check("msgTarget", msgTarget, q[0]);
        check("msgVector", msgVector, mVec);
        check("msgMode", msgMode, mMode);
        check("msgLogical", msgLogical, mLog);
      end
    end
    if (readyRandom != 0) msgReady = ($urandom % 3) != 0;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic issue(string tag, int line, int vec, int mode, bit lg, bit mk, int dest);
    @(negedge clk);
    curReq = tag;
    reqLine = 5'(line); reqVector = 8'(vec); reqMode = 3'(mode);
    reqLogical = lg; reqMask = mk; reqDest = 8'(dest); reqValid = 1;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    curReq = "R1";
    check("reset reqReady", reqReady, 1);
    check("reset msgValid", msgValid, 0);
    check("reset errors", {errRange, errReserved}, 0);

    issue("R6_R5_R11", 3, 8'h41, 0, 0, 0, 8'hC7);       // physical, full dest
    issue("R7_R5", 5, 8'h52, 1, 1, 0, 8'hA5);           // logical 0,2,5,7
    issue("R7_edge", 0, 8'h60, 4, 1, 0, 8'h80);         // only bit 7
    issue("R7_R11_all", 23, 8'hFE, 7, 1, 0, 8'hFF);     // every bit
    issue("R8", 2, 8'h33, 0, 1, 0, 8'h00);              // empty logical
    issue("R3", 4, 8'h44, 0, 1, 0, 8'hFF);
    issue("R3_mask", 4, 8'h44, 0, 1, 1, 8'hFF);
    issue("R2_lo", 24, 8'h10, 0, 0, 0, 8'h01);
    issue("R2_hi", 31, 8'h10, 3, 0, 1, 8'h01);          // range beats mask/reserved
    issue("R4_3", 6, 8'h20, 3, 0, 0, 8'h02);
    issue("R4_6", 7, 8'h21, 6, 1, 0, 8'h0F);
    issue("R4_masked", 7, 8'h22, 6, 0, 1, 8'h0F);       // mask wins, no error
    issue("R6_zero", 9, 8'h23, 2, 0, 0, 8'h00);         // physical ID 0
    issue("R5_mode5", 10, 8'h24, 5, 0, 0, 8'h0E);

    readyRandom = 1;                                    // back-pressure: R9 R10
    issue("R10_R9", 1, 8'h77, 0, 1, 0, 8'h5A);
    issue("R10_phys", 1, 8'h78, 1, 0, 0, 8'h3C);
    for (int n = 0; n < 300; n++)
      issue("R7_R10_rand", $urandom % 32, $urandom % 256, $urandom % 8,
            1'($urandom % 2), 1'(($urandom % 5) == 0), $urandom % 256);
    readyRandom = 0; msgReady = 1;

    // back-to-back requests held valid: R9 reqReady handling
    @(negedge clk);
    curReq = "R9_b2b";
    reqLine = 1; reqVector = 8'h90; reqMode = 0; reqLogical = 1; reqMask = 0;
    reqDest = 8'h11; reqValid = 1;
    repeat (12) @(negedge clk);
    reqValid = 0;
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule